// File: doc/BRIEF.md
# CPU Bus Memory and IO Router

This block sits between an 8-bit processor and the memories of a small home computer with a 64 KB address space. Each cycle it classifies the processor's bus strobes as a memory read, a memory write, an IO read, an IO write or no cycle at all. From that it raises the chip select and write enable for a 64 KB RAM, or the chip select for a 16 KB lower ROM or a 16 KB upper ROM. It also selects the byte that goes back to the processor.

The two ROMs overlay the bottom and top quarters of the address space. Reads in an enabled overlay return ROM data. Writes always go to the RAM underneath, so software can fill the RAM behind a ROM and read it back once the overlay is switched off. IO writes touch no storage, and IO reads return zero.

The memories read synchronously: an address presented with a select in one cycle gives its data in the next. The router registers which source was selected and muxes that source onto the processor's read bus one cycle after the read strobe.

Top module: `cpu_bus_router`

## Requirements
- R1: A memory read (mreq_i=1, iorq_i=0, rd_i=1, wr_i=0) at addresses 0x0000–0x3FFF with rom_lo_en_i=1 asserts rom_lo_cs_o alone, and the next cycle rdata_o equals rom_lo_rdata_i.
- R2: A memory read at 0xC000–0xFFFF with rom_hi_en_i=1 asserts rom_hi_cs_o alone, and the next cycle rdata_o equals rom_hi_rdata_i.
- R3: A memory read at 0x4000–0xBFFF asserts ram_cs_o with ram_we_o=0 whatever the overlay enables, and the next cycle rdata_o is the RAM byte at that address.
- R4: With the matching overlay enable at 0, a memory read inside that ROM window reads RAM: ram_cs_o=1, neither ROM select, and RAM data returned the next cycle.
- R5: A memory write (mreq_i=1, iorq_i=0, wr_i=1, rd_i=0) at any address asserts ram_cs_o and ram_we_o with no ROM select, and the RAM receives wdata_i at addr_i.
- R6: An IO write (iorq_i=1, mreq_i=0, wr_i=1, rd_i=0) asserts no select and no write enable, so no stored byte changes.
- R7: An IO read (iorq_i=1, mreq_i=0, rd_i=1, wr_i=0) asserts no select, and the next cycle rdata_o is 0x00.
- R8: At most one of ram_cs_o, rom_lo_cs_o and rom_hi_cs_o is high in any cycle. ram_we_o is never high without ram_cs_o. Nothing is selected when both request strobes are low, both are high, or both rd_i and wr_i are high (or both low). The cycle after any non-read, rdata_o is 0x00.
- R9: While rst_ni is low, and in the first cycle after it rises, rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| mreq_i | input | 1 | Memory request strobe |
| iorq_i | input | 1 | IO request strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rom_lo_en_i | input | 1 | Lower ROM overlay enable |
| rom_hi_en_i | input | 1 | Upper ROM overlay enable |
| ram_addr_o | output | 16 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 8 | RAM read data, one cycle after select |
| rom_addr_o | output | 14 | Shared ROM address |
| rom_lo_cs_o | output | 1 | Lower ROM chip select |
| rom_lo_rdata_i | input | 8 | Lower ROM read data |
| rom_hi_cs_o | output | 1 | Upper ROM chip select |
| rom_hi_rdata_i | input | 8 | Upper ROM read data |
| rdata_o | output | 8 | Read data to the CPU |

## Verification
The bench writes distinct bytes into all three windows. It then reads them back under all four combinations of the overlay enables, which shows whether a read came from a ROM or from the RAM hidden beneath it, and whether the write really reached RAM under an active overlay. IO reads and writes are placed between memory cycles to show that they return zero and leave RAM unchanged. Illegal strobe combinations (both requests, both directions, none) check that nothing is selected. A long random stream of mixed cycles, with the enables toggling, exercises the window edges at 0x3FFF/0x4000 and 0xBFFF/0xC000 against the behavioural model.

// File: rtl/bus_route_pkg.sv
package bus_route_pkg;
  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_MEM_RD,
    CYC_MEM_WR,
    CYC_IO_RD,
    CYC_IO_WR
  } cyc_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RAM,
    SRC_ROM_LO,
    SRC_ROM_HI,
    SRC_ZERO
  } src_e;
endpackage

// File: rtl/bus_cycle_classify.sv
module bus_cycle_classify
  import bus_route_pkg::*;
(
  input  logic mreq_i,
  input  logic iorq_i,
  input  logic rd_i,
  input  logic wr_i,
  output cyc_e cyc_o
);
  logic one_req;
  logic one_dir;

  assign one_req = mreq_i ^ iorq_i;
  assign one_dir = rd_i ^ wr_i;

  always_comb begin
    cyc_o = CYC_NONE;
    if (one_req && one_dir) begin
      if (mreq_i) cyc_o = rd_i ? CYC_MEM_RD : CYC_MEM_WR;
      else        cyc_o = rd_i ? CYC_IO_RD  : CYC_IO_WR;
    end
  end
endmodule

// File: rtl/bus_window_decode.sv
module bus_window_decode #(
  parameter int ADDR_W = 16,
  parameter int ROM_W  = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_lo_o,
  output logic              in_hi_o
);
  localparam int PAGE_W = ADDR_W - ROM_W;

  logic [PAGE_W-1:0] page;

  assign page    = addr_i[ADDR_W-1:ROM_W];
  assign in_lo_o = (page == {PAGE_W{1'b0}});
  assign in_hi_o = (page == {PAGE_W{1'b1}});
endmodule

// File: rtl/bus_select_gen.sv
module bus_select_gen
  import bus_route_pkg::*;
(
  input  cyc_e cyc_i,
  input  logic in_lo_i,
  input  logic in_hi_i,
  input  logic lo_en_i,
  input  logic hi_en_i,
  output logic ram_cs_o,
  output logic ram_we_o,
  output logic lo_cs_o,
  output logic hi_cs_o,
  output src_e src_o
);
  always_comb begin
    ram_cs_o = 1'b0;
    ram_we_o = 1'b0;
    lo_cs_o  = 1'b0;
    hi_cs_o  = 1'b0;
    src_o    = SRC_NONE;
    unique case (cyc_i)
      CYC_MEM_RD: begin
        if (in_lo_i && lo_en_i) begin
          lo_cs_o = 1'b1;
          src_o   = SRC_ROM_LO;
        end else if (in_hi_i && hi_en_i) begin
          hi_cs_o = 1'b1;
          src_o   = SRC_ROM_HI;
        end else begin
          ram_cs_o = 1'b1;
          src_o    = SRC_RAM;
        end
      end
      // writes ignore overlays: RAM lies under every ROM
      CYC_MEM_WR: begin
        ram_cs_o = 1'b1;
        ram_we_o = 1'b1;
      end
      CYC_IO_RD: src_o = SRC_ZERO;
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_rdata_mux.sv
module bus_rdata_mux
  import bus_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] lo_rdata_i,
  input  logic [DATA_W-1:0] hi_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  src_e src_q;

  // memories answer one cycle after select; follow them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_NONE;
    else         src_q <= src_i;
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM:    rdata_o = ram_rdata_i;
      SRC_ROM_LO: rdata_o = lo_rdata_i;
      SRC_ROM_HI: rdata_o = hi_rdata_i;
      default:    rdata_o = '0;
    endcase
  end

  AST_LO_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_ROM_LO) |=> (rdata_o == lo_rdata_i)); // R1
  AST_HI_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_ROM_HI) |=> (rdata_o == hi_rdata_i)); // R2
endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
  import bus_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              rom_lo_en_i,
  input  logic              rom_hi_en_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ROM_W-1:0]  rom_addr_o,
  output logic              rom_lo_cs_o,
  input  logic [DATA_W-1:0] rom_lo_rdata_i,
  output logic              rom_hi_cs_o,
  input  logic [DATA_W-1:0] rom_hi_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  cyc_e cyc;
  src_e src;
  logic in_lo;
  logic in_hi;

  bus_cycle_classify u_classify (
    .mreq_i (mreq_i),
    .iorq_i (iorq_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .cyc_o  (cyc)
  );

  bus_window_decode #(
    .ADDR_W (ADDR_W),
    .ROM_W  (ROM_W)
  ) u_window (
    .addr_i  (addr_i),
    .in_lo_o (in_lo),
    .in_hi_o (in_hi)
  );

  bus_select_gen u_select (
    .cyc_i    (cyc),
    .in_lo_i  (in_lo),
    .in_hi_i  (in_hi),
    .lo_en_i  (rom_lo_en_i),
    .hi_en_i  (rom_hi_en_i),
    .ram_cs_o (ram_cs_o),
    .ram_we_o (ram_we_o),
    .lo_cs_o  (rom_lo_cs_o),
    .hi_cs_o  (rom_hi_cs_o),
    .src_o    (src)
  );

  bus_rdata_mux #(
    .DATA_W (DATA_W)
  ) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src),
    .ram_rdata_i (ram_rdata_i),
    .lo_rdata_i  (rom_lo_rdata_i),
    .hi_rdata_i  (rom_hi_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign ram_addr_o  = addr_i;
  assign ram_wdata_o = wdata_i;
  assign rom_addr_o  = addr_i[ROM_W-1:0];

  localparam int PAGE_W = ADDR_W - ROM_W;
  logic mem_rd_bus;
  logic mem_wr_bus;
  logic io_rd_bus;
  logic io_wr_bus;
  logic page_lo;
  logic page_hi;
  assign mem_rd_bus = mreq_i && !iorq_i && rd_i && !wr_i;
  assign mem_wr_bus = mreq_i && !iorq_i && wr_i && !rd_i;
  assign io_rd_bus  = iorq_i && !mreq_i && rd_i && !wr_i;
  assign io_wr_bus  = iorq_i && !mreq_i && wr_i && !rd_i;
  assign page_lo    = (addr_i[ADDR_W-1:ROM_W] == {PAGE_W{1'b0}});
  assign page_hi    = (addr_i[ADDR_W-1:ROM_W] == {PAGE_W{1'b1}});

  AST_LO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_bus && page_lo && rom_lo_en_i) |-> (rom_lo_cs_o && !ram_cs_o)); // R1
  AST_HI_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_bus && page_hi && rom_hi_en_i) |-> (rom_hi_cs_o && !ram_cs_o)); // R2
  AST_MID_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_bus && !page_lo && !page_hi) |-> (ram_cs_o && !ram_we_o)); // R3
  AST_OVERLAY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_bus && ((page_lo && !rom_lo_en_i) || (page_hi && !rom_hi_en_i)))
      |-> (ram_cs_o && !rom_lo_cs_o && !rom_hi_cs_o)); // R4
  AST_WRITE_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_bus |-> (ram_cs_o && ram_we_o && !rom_lo_cs_o && !rom_hi_cs_o)); // R5
  AST_IO_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_bus |-> !(ram_cs_o || rom_lo_cs_o || rom_hi_cs_o)); // R6
  AST_IO_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_bus |=> (rdata_o == '0)); // R7
  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs_o, rom_lo_cs_o, rom_hi_cs_o}) && (!ram_we_o || ram_cs_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_i && !iorq_i) |-> !(ram_cs_o || ram_we_o || rom_lo_cs_o || rom_hi_cs_o)); // R8
  AST_NONREAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_bus) |=> (rdata_o == '0 || $past(mem_rd_bus))); // R8
endmodule

// File: tb/cpu_bus_router_bench.sv
module cpu_bus_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mreq = 1'b0, iorq = 1'b0, rd = 1'b0, wr = 1'b0;
  logic        lo_en = 1'b1, hi_en = 1'b1;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_cs, ram_we;
  logic [7:0]  ram_rdata = '0;
  logic [13:0] rom_addr;
  logic        lo_cs, hi_cs;
  logic [7:0]  lo_rdata = '0, hi_rdata = '0;
  logic [7:0]  rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  cpu_bus_router u_cpu_bus_router (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .mreq_i(mreq), .iorq_i(iorq), .rd_i(rd), .wr_i(wr),
    .rom_lo_en_i(lo_en), .rom_hi_en_i(hi_en),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_cs_o(ram_cs),
    .ram_we_o(ram_we), .ram_rdata_i(ram_rdata), .rom_addr_o(rom_addr),
    .rom_lo_cs_o(lo_cs), .rom_lo_rdata_i(lo_rdata), .rom_hi_cs_o(hi_cs),
    .rom_hi_rdata_i(hi_rdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] ram_init(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] rom_lo_val(input logic [13:0] a);
    return (a[7:0] + 8'h11) ^ {2'b00, a[13:8]};
  endfunction
  function automatic logic [7:0] rom_hi_val(input logic [13:0] a);
    return ~a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  // memory devices driven by the DUT's selects
  logic [7:0] ram_dev [int];
  always @(posedge clk) begin
    if (ram_cs) begin
      if (ram_we) ram_dev[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= ram_dev.exists(int'(ram_addr)) ? ram_dev[int'(ram_addr)] : ram_init(ram_addr);
    end
    if (lo_cs) lo_rdata <= rom_lo_val(rom_addr);
    if (hi_cs) hi_rdata <= rom_hi_val(rom_addr);
  end

  // behavioural reference
  logic [7:0] ref_ram [int];
  logic [7:0] exp_rdata = '0;
  string      rd_tag = "R9";

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return ref_ram.exists(int'(a)) ? ref_ram[int'(a)] : ram_init(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rdata = '0;
      rd_tag = "R9";
    end else begin
      bit m_rd, m_wr, i_rd, win_lo, win_hi;
      m_rd = mreq && !iorq && rd && !wr;
      m_wr = mreq && !iorq && wr && !rd;
      i_rd = iorq && !mreq && rd && !wr;
      win_lo = addr < 16'h4000;
      win_hi = addr >= 16'hC000;
      if (m_rd && win_lo && lo_en)      begin exp_rdata = rom_lo_val(addr[13:0]); rd_tag = "R1"; end
      else if (m_rd && win_hi && hi_en) begin exp_rdata = rom_hi_val(addr[13:0]); rd_tag = "R2"; end
      else if (m_rd)                    begin exp_rdata = ref_rd(addr); rd_tag = (win_lo || win_hi) ? "R4" : "R3"; end
      else if (i_rd)                    begin exp_rdata = 8'h00; rd_tag = "R7"; end
      else                              begin exp_rdata = 8'h00; rd_tag = "R8"; end
      if (m_wr) ref_ram[int'(addr)] = wdata;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      bit m_rd, m_wr, i_wr, win_lo, win_hi, e_lo, e_hi, e_ram;
      string tag;
      m_rd = mreq && !iorq && rd && !wr;
      m_wr = mreq && !iorq && wr && !rd;
      i_wr = iorq && !mreq && wr && !rd;
      win_lo = addr < 16'h4000;
      win_hi = addr >= 16'hC000;
      e_lo = m_rd && win_lo && lo_en;
      e_hi = m_rd && win_hi && hi_en;
      e_ram = m_wr || (m_rd && !e_lo && !e_hi);
      if (m_wr) tag = "R5";
      else if (i_wr) tag = "R6";
      else if (e_lo) tag = "R1";
      else if (e_hi) tag = "R2";
      else if (m_rd) tag = (win_lo || win_hi) ? "R4" : "R3";
      else tag = "R8";
      check(tag, "ram_cs", int'(ram_cs), int'(e_ram));
      check(tag, "ram_we", int'(ram_we), int'(m_wr));
      check(tag, "rom_lo_cs", int'(lo_cs), int'(e_lo));
      check(tag, "rom_hi_cs", int'(hi_cs), int'(e_hi));
      if (m_wr) begin
        check("R5", "ram_addr", int'(ram_addr), int'(addr));
        check("R5", "ram_wdata", int'(ram_wdata), int'(wdata));
      end
      check(rd_tag, "rdata", int'(rdata), int'(exp_rdata));
    end
  end

  task automatic cyc(input bit m, input bit i, input bit r, input bit w,
                     input logic [15:0] a, input logic [7:0] d);
    @(posedge clk);
    #1;
    mreq = m; iorq = i; rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [7:0] d); cyc(1, 0, 0, 1, a, d); endtask
  task automatic mem_rd(input logic [15:0] a); cyc(1, 0, 1, 0, a, 8'h00); endtask
  task automatic io_wr(input logic [15:0] a, input logic [7:0] d); cyc(0, 1, 0, 1, a, d); endtask
  task automatic io_rd(input logic [15:0] a); cyc(0, 1, 1, 0, a, 8'h00); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 16'h0000, 8'h00); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #3;
    check("R9", "rdata in reset", int'(rdata), 0);
    check("R9", "ram_cs in reset", int'(ram_cs), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9", "rdata after reset", int'(rdata), 0);
    chk_on = 1'b1;

    // fill bytes under both overlays and in the middle (R5)
    lo_en = 1'b1; hi_en = 1'b1;
    mem_wr(16'h0000, 8'hA1);
    mem_wr(16'h3FFF, 8'hA2);
    mem_wr(16'h4000, 8'hB1);
    mem_wr(16'hBFFF, 8'hB2);
    mem_wr(16'hC000, 8'hC1);
    mem_wr(16'hFFFF, 8'hC2);
    // overlays on: R1, R2, R3
    foreach (bench_addrs[k]) mem_rd(bench_addrs[k]);
    idle();
    // IO cycles between memory traffic (R6, R7)
    io_wr(16'h0000, 8'h55);
    io_rd(16'h4000);
    io_wr(16'hC000, 8'h77);
    io_rd(16'h00FF);
    mem_rd(16'h4000);
    // all overlay combinations (R4)
    for (int e = 0; e < 4; e++) begin
      cyc(0, 0, 0, 0, 16'h0000, 8'h00);
      lo_en = e[0]; hi_en = e[1];
      foreach (bench_addrs[k]) mem_rd(bench_addrs[k]);
    end
    // illegal strobe mixes (R8)
    cyc(1, 1, 1, 0, 16'h0000, 8'h00);
    cyc(1, 1, 0, 1, 16'h4000, 8'h12);
    cyc(1, 0, 1, 1, 16'hC000, 8'h34);
    cyc(0, 1, 1, 1, 16'h8000, 8'h56);
    cyc(1, 0, 0, 0, 16'h1234, 8'h00);
    mem_rd(16'hC000);
    lo_en = 1'b0; hi_en = 1'b0;
    mem_rd(16'h4000);
    mem_rd(16'hC000);
    // random mixed stream
    for (int n = 0; n < 6000; n++) begin
      int kind;
      logic [15:0] a;
      kind = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = 16'h3FFC + 16'($urandom_range(0, 7));
        1: a = 16'hBFFC + 16'($urandom_range(0, 7));
        default: a = 16'($urandom);
      endcase
      if ((n % 97) == 0) begin
        lo_en = $urandom_range(0, 1) != 0;
        hi_en = $urandom_range(0, 1) != 0;
      end
      case (kind)
        0, 1, 2: mem_wr(a, 8'($urandom));
        3, 4, 5, 6: mem_rd(a);
        7: io_rd(a);
        8: io_wr(a, 8'($urandom));
        default: cyc($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
                     $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, a, 8'($urandom));
      endcase
    end
    idle();
    idle();
    @(negedge clk);
    chk_on = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  logic [15:0] bench_addrs [6] = '{16'h0000, 16'h3FFF, 16'h4000, 16'hBFFF, 16'hC000, 16'hFFFF};
endmodule